// File: doc/BRIEF.md
# Single-Phase PCI Target Front End

This block sits behind the AD, C/BE#, FRAME#, IRDY# and IDSEL lines of a 32-bit PCI agent and acts as its target-side front end. On the first clock of a transaction it captures the command and the address. It sorts the command into memory, configuration or unsupported. For memory commands it checks the address against two base regions: one holds the control registers and the other the internal memory. It claims the access only when the command is supported and the address qualifies.

A claimed access always gets exactly one data phase. The block asserts TRDY# and STOP# together, so the master completes one transfer and is then disconnected. The read-multiple and read-line commands are handled as plain memory reads, and write-and-invalidate as a plain memory write. Target abort is never signalled. Memory apertures accept only full doubleword byte enables. A memory access with partial enables still completes, but it has no effect. Configuration accesses may enable any mix of bytes.

Each qualified data phase becomes a one-cycle request to a back-end register port. The request carries the space, address, byte enables, write data and direction. The back end answers with read data in the same cycle, and the block returns that data on AD.

Top module: `pci_tgt_front`

## Requirements
- R1: Commands are decoded from C/BE# (active-low values as binary) during the address phase. 0110, 1100 and 1110 are memory reads. 0111 and 1111 are memory writes. 1010 is a configuration read and 1011 a configuration write. The request direction `req_write` equals bit 0 of the command.
- R2: The codes 0000, 0001, 0010, 0011 and 1101, and every other code not listed in R1, are never claimed. DEVSEL#, TRDY# and STOP# stay high, and `req_valid` stays low, for the whole transaction.
- R3: A configuration command is claimed only when IDSEL is high and AD[1:0] is 00 during the address phase. The request space is then 0.
- R4: A memory command is claimed only when `mem_en` is high and the address lies in a region. Addresses that match `reg_base` above bit REG_APERT_BITS give space 1. Addresses that match `mem_base` above bit MEM_APERT_BITS give space 2. Any other address is not claimed.
- R5: For a claimed access, DEVSEL# goes low on the clock edge that samples the address phase. At that point TRDY# and STOP# are still high.
- R6: In a claimed access, TRDY# and STOP# go low together two edges after IRDY# is first sampled low. TRDY# stays low for exactly one data phase. STOP# is never high while TRDY# is low.
- R7: STOP# is never low while DEVSEL# is high, so target abort never occurs.
- R8: A qualified data phase raises `req_valid` for exactly one cycle, on the edge after IRDY# is sampled low. During that cycle `req_addr`, `req_be` (active-high, equal to the inverse of C/BE#), `req_wdata`, `req_write` and `req_space` describe the access.
- R9: A claimed memory access whose C/BE# is not 0000 raises no `req_valid`. It still completes with TRDY# and STOP#, and a read returns zero on AD.
- R10: A configuration access passes through any byte-enable pattern on `req_be` unchanged.
- R11: During a read data phase `ad_oe` is high and `ad_out` carries the back-end `rsp_rdata` captured in the request cycle. `ad_oe` is low at all other times and for every write.
- R12: While `rst` is high and after it is released, DEVSEL#, TRDY# and STOP# are high and `ad_oe` and `req_valid` are low until a transaction starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Transaction framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select |
| cbe_n | input | 4 | Command / byte enables, active low |
| ad_in | input | 32 | Address/data bus, sampled value |
| mem_en | input | 1 | Memory-space decode enable |
| reg_base | input | 32 | Base address of the register region |
| mem_base | input | 32 | Base address of the memory region |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Disconnect request, active low |
| ad_out | output | 32 | Read data driven onto AD |
| ad_oe | output | 1 | AD output enable |
| req_valid | output | 1 | One-cycle back-end request strobe |
| req_space | output | 2 | 0 config, 1 registers, 2 memory |
| req_addr | output | 32 | Captured address |
| req_be | output | 4 | Byte enables, active high |
| req_wdata | output | 32 | Write data |
| req_write | output | 1 | 1 for write, 0 for read |
| rsp_rdata | input | 32 | Back-end read data, valid while req_valid |

## Verification
The bench sends the aliased commands and checks that their space and direction match the plain commands. A decoder that missed an alias would leave DEVSEL# high, and one that misread bit 0 would turn a write-and-invalidate into a read. It sends every unsupported code and then holds IRDY# through the abort window, watching DEVSEL#, STOP# and `req_valid`. A design that claimed loosely would answer an I/O or special cycle, or signal a disconnect without DEVSEL#.

For configuration commands it drops IDSEL and sets AD[1:0] to 01. These catch a decoder that claims type-1 cycles or configuration cycles meant for another device. It also sends partial byte enables to both apertures and to configuration space. A design that forwarded a partial memory write would corrupt back-end state, and one that rejected partial configuration enables would break byte-wide accesses. The bench also clears `mem_en` and uses addresses at the upper edge of a region and just outside both regions.

// File: rtl/pcit_pkg.sv
package pcit_pkg;
  typedef enum logic [1:0] {
    SP_CFG = 2'd0,
    SP_REG = 2'd1,
    SP_MEM = 2'd2
  } space_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLAIM,
    ST_ACCESS,
    ST_DONE,
    ST_WAITEND,
    ST_BUSY
  } seq_e;

  localparam int unsigned NUM_REGIONS = 2;
endpackage

// File: rtl/pcit_cmd_decode.sv
module pcit_cmd_decode (
  input  logic [3:0] cmd_n,
  output logic       is_mem,
  output logic       is_cfg,
  output logic       is_wr
);
  always_comb begin
    is_mem = 1'b0;
    is_cfg = 1'b0;
    case (cmd_n)
      4'b0110, 4'b1100, 4'b1110: is_mem = 1'b1;
      4'b0111, 4'b1111:          is_mem = 1'b1;
      4'b1010, 4'b1011:          is_cfg = 1'b1;
      default: ;
    endcase
    is_wr = cmd_n[0];
  end
endmodule

// File: rtl/pcit_region_match.sv
module pcit_region_match #(
  parameter int unsigned AW          = 32,
  parameter int unsigned APERT_BITS  = 12
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic          enable,
  output logic          hit
);
  localparam int unsigned TAG_W = AW - APERT_BITS;
  logic [TAG_W-1:0] addr_tag, base_tag;
  assign addr_tag = addr[AW-1:APERT_BITS];
  assign base_tag = base[AW-1:APERT_BITS];
  assign hit = enable && (addr_tag == base_tag);
endmodule

// File: rtl/pcit_seq.sv
module pcit_seq
  import pcit_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic claim,
  input  logic is_read,
  output logic addr_cap,
  output logic data_cap,
  output logic resp_load,
  output logic devsel_n,
  output logic trdy_n,
  output logic stop_n,
  output logic ad_oe
);
  seq_e state;

  assign addr_cap  = (state == ST_IDLE) && !frame_n;
  assign data_cap  = (state == ST_CLAIM) && !irdy_n;
  assign resp_load = (state == ST_ACCESS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
      ad_oe    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!frame_n) begin
            if (claim) begin
              state    <= ST_CLAIM;
              devsel_n <= 1'b0;
            end else begin
              state <= ST_BUSY;
            end
          end
        end
        ST_CLAIM: begin
          if (!irdy_n) state <= ST_ACCESS;
        end
        ST_ACCESS: begin
          trdy_n <= 1'b0;
          stop_n <= 1'b0;
          ad_oe  <= is_read;
          state  <= ST_DONE;
        end
        ST_DONE: begin
          if (!irdy_n) begin
            trdy_n <= 1'b1;
            ad_oe  <= 1'b0;
            if (frame_n) begin
              devsel_n <= 1'b1;
              stop_n   <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              state <= ST_WAITEND;
            end
          end
        end
        ST_WAITEND: begin
          if (frame_n) begin
            devsel_n <= 1'b1;
            stop_n   <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        ST_BUSY: begin
          if (frame_n && irdy_n) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_tgt_front.sv
module pci_tgt_front
  import pcit_pkg::*;
#(
  parameter int unsigned AW              = 32,
  parameter int unsigned DW              = 32,
  parameter int unsigned BEW             = DW / 8,
  parameter int unsigned REG_APERT_BITS  = 12,
  parameter int unsigned MEM_APERT_BITS  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           frame_n,
  input  logic           irdy_n,
  input  logic           idsel,
  input  logic [BEW-1:0] cbe_n,
  input  logic [AW-1:0]  ad_in,
  input  logic           mem_en,
  input  logic [AW-1:0]  reg_base,
  input  logic [AW-1:0]  mem_base,
  output logic           devsel_n,
  output logic           trdy_n,
  output logic           stop_n,
  output logic [DW-1:0]  ad_out,
  output logic           ad_oe,
  output logic           req_valid,
  output logic [1:0]     req_space,
  output logic [AW-1:0]  req_addr,
  output logic [BEW-1:0] req_be,
  output logic [DW-1:0]  req_wdata,
  output logic           req_write,
  input  logic [DW-1:0]  rsp_rdata
);
  logic is_mem, is_cfg, is_wr;
  logic [NUM_REGIONS-1:0] rgn_hit;
  logic cfg_hit, claim;
  space_e space_d, space_q;
  logic addr_cap, data_cap, resp_load;
  logic [AW-1:0] addr_q;
  logic wr_q, drop_q;
  logic [BEW-1:0] be_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic full_be;

  pcit_cmd_decode u_dec (
    .cmd_n  (cbe_n),
    .is_mem (is_mem),
    .is_cfg (is_cfg),
    .is_wr  (is_wr)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
    localparam int unsigned BITS = (g == 0) ? REG_APERT_BITS : MEM_APERT_BITS;
    pcit_region_match #(
      .AW         (AW),
      .APERT_BITS (BITS)
    ) u_match (
      .addr   (ad_in),
      .base   ((g == 0) ? reg_base : mem_base),
      .enable (is_mem && mem_en),
      .hit    (rgn_hit[g])
    );
  end

  assign cfg_hit = is_cfg && idsel && (ad_in[1:0] == 2'b00);
  assign claim   = cfg_hit || (|rgn_hit);

  always_comb begin
    if (cfg_hit)         space_d = SP_CFG;
    else if (rgn_hit[0]) space_d = SP_REG;
    else                 space_d = SP_MEM;
  end

  pcit_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .claim     (claim),
    .is_read   (!wr_q),
    .addr_cap  (addr_cap),
    .data_cap  (data_cap),
    .resp_load (resp_load),
    .devsel_n  (devsel_n),
    .trdy_n    (trdy_n),
    .stop_n    (stop_n),
    .ad_oe     (ad_oe)
  );

  assign full_be = (cbe_n == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      space_q   <= SP_CFG;
      wr_q      <= 1'b0;
      be_q      <= '0;
      wdata_q   <= '0;
      drop_q    <= 1'b0;
      req_valid <= 1'b0;
      rdata_q   <= '0;
    end else begin
      req_valid <= 1'b0;
      if (addr_cap) begin
        addr_q  <= ad_in;
        space_q <= space_d;
        wr_q    <= is_wr;
      end
      if (data_cap) begin
        be_q      <= ~cbe_n;
        wdata_q   <= ad_in;
        drop_q    <= !(space_q == SP_CFG || full_be);
        req_valid <= (space_q == SP_CFG) || full_be;
      end
      if (resp_load) begin
        rdata_q <= drop_q ? '0 : rsp_rdata;
      end
    end
  end

  assign ad_out    = rdata_q;
  assign req_space = space_q;
  assign req_addr  = addr_q;
  assign req_be    = be_q;
  assign req_wdata = wdata_q;
  assign req_write = wr_q;
endmodule

// File: rtl/pcit_front_chk.sv
module pcit_front_chk (
  input logic       clk,
  input logic       rst,
  input logic       devsel_n,
  input logic       trdy_n,
  input logic       stop_n,
  input logic       ad_oe,
  input logic       req_valid,
  input logic [1:0] req_space,
  input logic [3:0] req_be
);
  // R7
  no_target_abort_chk: assert property (@(posedge clk) disable iff (rst)
    !stop_n |-> !devsel_n);

  // R6
  trdy_with_stop_chk: assert property (@(posedge clk) disable iff (rst)
    !trdy_n |-> !stop_n);

  // R5
  devsel_first_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |-> (trdy_n && stop_n));

  // R8
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  // R9
  mem_full_be_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_space != 2'd0) |-> (req_be == 4'hF));

  // R11
  oe_in_data_phase_chk: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> !trdy_n);
endmodule

bind pci_tgt_front pcit_front_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .devsel_n  (devsel_n),
  .trdy_n    (trdy_n),
  .stop_n    (stop_n),
  .ad_oe     (ad_oe),
  .req_valid (req_valid),
  .req_space (req_space),
  .req_be    (req_be)
);

// File: tb/pci_tgt_front_test.sv
module pci_tgt_front_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] REG_BASE = 32'h1000_0000;
  localparam logic [31:0] MEM_BASE = 32'h2000_0000;
  localparam int NVEC = 17;

  // {cmd[44:41], idsel[40], addr[39:8], ben[7:4], claim[3], space[2:1], req[0]}
  localparam logic [44:0] VEC [NVEC] = '{
    {4'h6, 1'b0, 32'h1000_0010, 4'h0, 1'b1, 2'd1, 1'b1},
    {4'h7, 1'b0, 32'h1000_0020, 4'h0, 1'b1, 2'd1, 1'b1},
    {4'hC, 1'b0, 32'h2000_0100, 4'h0, 1'b1, 2'd2, 1'b1},
    {4'hE, 1'b0, 32'h2000_FFFC, 4'h0, 1'b1, 2'd2, 1'b1},
    {4'hF, 1'b0, 32'h2000_0008, 4'h0, 1'b1, 2'd2, 1'b1},
    {4'hA, 1'b1, 32'h0000_0040, 4'h3, 1'b1, 2'd0, 1'b1},
    {4'hB, 1'b1, 32'h0000_00E0, 4'hE, 1'b1, 2'd0, 1'b1},
    {4'hA, 1'b0, 32'h0000_0040, 4'h0, 1'b0, 2'd0, 1'b0},
    {4'hA, 1'b1, 32'h0000_0041, 4'h0, 1'b0, 2'd0, 1'b0},
    {4'h2, 1'b0, 32'h1000_0010, 4'h0, 1'b0, 2'd0, 1'b0},
    {4'h3, 1'b0, 32'h1000_0010, 4'h0, 1'b0, 2'd0, 1'b0},
    {4'h0, 1'b0, 32'h1000_0010, 4'h0, 1'b0, 2'd0, 1'b0},
    {4'h1, 1'b0, 32'h1000_0010, 4'h0, 1'b0, 2'd0, 1'b0},
    {4'hD, 1'b0, 32'h2000_0000, 4'h0, 1'b0, 2'd0, 1'b0},
    {4'h6, 1'b0, 32'h3000_0000, 4'h0, 1'b0, 2'd0, 1'b0},
    {4'h7, 1'b0, 32'h1000_0004, 4'h3, 1'b1, 2'd1, 1'b0},
    {4'h6, 1'b0, 32'h2001_0000, 4'h0, 1'b0, 2'd0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0, mem_en = 1'b1;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic        devsel_n, trdy_n, stop_n, ad_oe, req_valid, req_write;
  logic [31:0] ad_out, req_addr, req_wdata, rsp_rdata;
  logic [1:0]  req_space;
  logic [3:0]  req_be;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // back-end model: read data derived from the request address
  assign rsp_rdata = ~req_addr;

  pci_tgt_front uut (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .cbe_n(cbe_n), .ad_in(ad_in), .mem_en(mem_en), .reg_base(REG_BASE),
    .mem_base(MEM_BASE), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .req_valid(req_valid), .req_space(req_space),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_write(req_write), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic [3:0] cmd, input logic id, input logic [31:0] addr,
                         input logic [3:0] ben, input logic [31:0] wd, input logic claim,
                         input logic [1:0] sp, input logic req, input string grp);
    @(negedge clk);
    frame_n = 1'b0; cbe_n = cmd; ad_in = addr; idsel = id;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; cbe_n = ben; ad_in = wd; idsel = 1'b0;
    check({grp, " R5 devsel"}, {31'b0, devsel_n}, {31'b0, !claim});
    check("R5 trdy high at claim", {31'b0, trdy_n}, 32'd1);
    if (claim) begin
      @(negedge clk);
      check({grp, " R8 req_valid"}, {31'b0, req_valid}, {31'b0, req});
      if (req) begin
        check("R8 req_space", {30'b0, req_space}, {30'b0, sp});
        check("R8 req_addr", req_addr, addr);
        check("R10 R8 req_be", {28'b0, req_be}, {28'b0, ~ben});
        check("R1 req_write", {31'b0, req_write}, {31'b0, cmd[0]});
        if (cmd[0]) check("R8 req_wdata", req_wdata, wd);
      end
      @(negedge clk);
      check("R6 trdy low", {31'b0, trdy_n}, 32'd0);
      check("R6 stop low", {31'b0, stop_n}, 32'd0);
      check("R7 devsel held", {31'b0, devsel_n}, 32'd0);
      check("R11 ad_oe", {31'b0, ad_oe}, {31'b0, !cmd[0]});
      if (!cmd[0]) check(req ? "R11 read data" : "R9 dropped read data",
                         ad_out, req ? ~addr : 32'h0);
      @(negedge clk);
      irdy_n = 1'b1;
      check("R6 trdy released", {31'b0, trdy_n}, 32'd1);
      check("R6 stop released", {31'b0, stop_n}, 32'd1);
      check("R6 devsel released", {31'b0, devsel_n}, 32'd1);
      check("R11 ad_oe released", {31'b0, ad_oe}, 32'd0);
    end else begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        check({grp, " devsel idle"}, {31'b0, devsel_n}, 32'd1);
        check({grp, " stop idle"}, {31'b0, stop_n}, 32'd1);
        check({grp, " no request"}, {31'b0, req_valid}, 32'd0);
      end
      irdy_n = 1'b1;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 devsel in reset", {31'b0, devsel_n}, 32'd1);
    check("R12 trdy in reset", {31'b0, trdy_n}, 32'd1);
    check("R12 stop in reset", {31'b0, stop_n}, 32'd1);
    check("R12 oe in reset", {31'b0, ad_oe}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R12 req after reset", {31'b0, req_valid}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [44:0] v;
      string grp;
      v = VEC[i];
      if (!v[3])                 grp = "R2 R3 R4";
      else if (!v[0])            grp = "R9";
      else if (v[2:1] == 2'd0)   grp = (v[7:4] != 4'h0) ? "R10 R3" : "R3";
      else if (v[44:41] == 4'h6 || v[44:41] == 4'h7) grp = "R4";
      else                       grp = "R1";
      run_txn(v[44:41], v[40], v[39:8], v[7:4], 32'h5A5A_0000 | 32'(i),
              v[3], v[2:1], v[0], grp);
    end

    // R4 memory decode disabled: region address not claimed
    mem_en = 1'b0;
    run_txn(4'h6, 1'b0, 32'h1000_0100, 4'h0, 32'h0, 1'b0, 2'd0, 1'b0, "R4 mem_en off");
    // R3 config still claimed with memory decode off
    run_txn(4'hB, 1'b1, 32'h0000_00FC, 4'h0, 32'hCAFE_F00D, 1'b1, 2'd0, 1'b1, "R3 cfg mem_en off");
    mem_en = 1'b1;
    // R4 top of register region
    run_txn(4'h6, 1'b0, 32'h1000_0FFC, 4'h0, 32'h0, 1'b1, 2'd1, 1'b1, "R4 reg top");
    run_txn(4'h6, 1'b0, 32'h1000_1000, 4'h0, 32'h0, 1'b0, 2'd0, 1'b0, "R4 reg past end");
    // R9 partial write to memory aperture
    run_txn(4'hF, 1'b0, 32'h2000_0010, 4'h7, 32'h1234_5678, 1'b1, 2'd2, 1'b0, "R9");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule